// File: doc/BRIEF.md
# Asynchronous Byte-Wide SRAM Bus Controller

This block sits between a synchronous host port and an external asynchronous static RAM that is eight bits wide. The host offers one request at a time over a valid/ready handshake. A request carries a direction bit, a 13-bit address and, for a store, one data byte. The controller then drives three active-low SRAM strobes: chip select, output enable and write strobe. It also drives the address lines and a tri-state data bus, which is split into an output value, an output-drive enable and an input value. Every edge is placed so that the nanosecond minimums of the memory are met.

All timing comes from one clock-period parameter and a set of nanosecond parameters. Each interval is rounded up to whole clock cycles. A load returns the byte it sampled together with a one-cycle response strobe. A store returns a one-cycle completion strobe. The host port stays busy until the whole cycle has elapsed, including the address hold that follows the strobes, so no handshake logic is needed beyond ready.

Top module: `sram_async_ctrl`

## Requirements
- R1: While reset is held, and in the cycle after it is released, `req_ready` is 1. `sram_ce_n`, `sram_oe_n` and `sram_we_n` are 1, and `dq_oe`, `rsp_valid` and `wr_done` are 0.
- R2: A request is accepted at a clock edge where `req_valid` and `req_ready` are both 1 and `req_we` is 0. For the next RD_ACT cycles, `sram_ce_n` and `sram_oe_n` are 0 and `sram_we_n` is 1. RD_ACT is the larger of the cycle counts for 100 ns and for 50 ns, which is 20 at 5 ns.
- R3: A request accepted with `req_we` 1 holds `sram_ce_n` and `sram_we_n` at 0 and `sram_oe_n` at 1 for WR_ACT cycles. WR_ACT is the largest of the counts for the 80 ns pulse, the 80 ns address-to-rise time and the 50 ns data setup, which is 16 at 5 ns. The write strobe is never low while chip select is high or output enable is low.
- R4: For a store, `dq_oe` is 1 with `dq_o` equal to the request byte. This lasts from the cycle after acceptance until DH cycles after the strobes rise, where DH is the count for 5 ns. `dq_oe` is never 1 while `sram_oe_n` is 0.
- R5: `sram_addr` equals the accepted address from the cycle after acceptance until `req_ready` returns to 1.
- R6: `req_ready` is 0 for exactly ACT+TAIL cycles after acceptance. For a load, TAIL is the larger of the 10 ns hold count and the cycle count for 100 ns minus RD_ACT. For a store, TAIL is the largest of the 10 ns count, DH, and the cycle count for 100 ns minus WR_ACT.
- R7: Every cycle count equals the ceiling of the nanosecond value divided by the clock period, and is at least 1.
- R8: After a load, `rsp_valid` is 1 for exactly one cycle, RD_ACT cycles after acceptance. `rsp_rdata` then holds the byte present on `dq_i` at the clock edge where the strobes rise. That byte is the last value stored to that address.
- R9: After a store, `wr_done` is 1 for exactly one cycle, WR_ACT cycles after acceptance. `rsp_valid` and `wr_done` are never 1 together.
- R10: A request held valid while the port is busy has no effect until `req_ready` is 1. It is then accepted in the first ready cycle, which gives back-to-back cycles with no idle gap.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | Host request present |
| req_we | input | 1 | 1 = store, 0 = load |
| req_addr | input | ADDR_W (13) | Byte address |
| req_wdata | input | DATA_W (8) | Store data |
| req_ready | output | 1 | Port can accept a request |
| rsp_valid | output | 1 | Load data valid pulse |
| rsp_rdata | output | DATA_W (8) | Loaded byte |
| wr_done | output | 1 | Store complete pulse |
| sram_addr | output | ADDR_W (13) | SRAM address lines |
| sram_ce_n | output | 1 | Chip select, active low |
| sram_oe_n | output | 1 | Output enable, active low |
| sram_we_n | output | 1 | Write strobe, active low |
| dq_o | output | DATA_W (8) | Data bus drive value |
| dq_oe | output | 1 | Data bus drive enable |
| dq_i | input | DATA_W (8) | Data bus sampled value |

## Verification
The hardest situation to reach is the seam between two cycles. Here the write-data hold, the address hold and the next acceptance all fall within a few cycles of each other, and a store is followed at once by a load of the same address. The stimulus holds each request valid through the busy period with no gap, so acceptance lands in the first ready cycle. Store/load pairs on the same address go through a pin-level memory model in the bench, so a load only returns the right byte if the earlier store's strobes and data drive were correct at the pins.

// File: rtl/sram_ctrl_pkg.sv
// Shared types and cycle-count helpers for the asynchronous SRAM controller.
// Assumes all nanosecond values and the clock period are positive integers.
package sram_ctrl_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_ACT  = 2'd1,
        ST_TAIL = 2'd2
    } bus_state_e;

    // Round a nanosecond interval up to whole clock cycles, never below one.
    function automatic int ns_to_cyc(input int ns, input int clk_ns);
        int c;
        c = (ns + clk_ns - 1) / clk_ns;
        return (c < 1) ? 1 : c;
    endfunction

    function automatic int imax2(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    function automatic int imax3(input int a, input int b, input int c);
        return imax2(imax2(a, b), c);
    endfunction

endpackage

// File: rtl/sram_ctrl_fsm.sv
// Strobe sequencer: IDLE -> ACT (strobes low) -> TAIL (address/data hold).
// Assumes ACT and TAIL counts are at least 1 and WR_TAIL >= DH_CYC.
module sram_ctrl_fsm
    import sram_ctrl_pkg::*;
#(
    parameter int RD_ACT  = 20,
    parameter int WR_ACT  = 16,
    parameter int RD_TAIL = 2,
    parameter int WR_TAIL = 4,
    parameter int DH_CYC  = 1,
    parameter int CNT_W   = 5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic req_valid,
    input  logic req_we,
    output logic req_ready,
    output logic accept,
    output logic capture,
    output logic is_wr,
    output logic ce_n,
    output logic oe_n,
    output logic we_n,
    output logic drive
);

    bus_state_e       state;
    logic [CNT_W-1:0] cnt;
    logic [15:0]      we_low_run;

    assign req_ready = (state == ST_IDLE);
    assign accept    = req_ready && req_valid;
    assign capture   = (state == ST_ACT) && (cnt == '0);

    // Sequence the strobes, the phase counter and the data-drive window.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            cnt   <= '0;
            is_wr <= 1'b0;
            ce_n  <= 1'b1;
            oe_n  <= 1'b1;
            we_n  <= 1'b1;
            drive <= 1'b0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (req_valid) begin
                        state <= ST_ACT;
                        is_wr <= req_we;
                        cnt   <= req_we ? CNT_W'(WR_ACT - 1) : CNT_W'(RD_ACT - 1);
                        ce_n  <= 1'b0;
                        oe_n  <= req_we;
                        we_n  <= !req_we;
                        drive <= req_we;
                    end
                end
                ST_ACT: begin
                    if (cnt == '0) begin
                        state <= ST_TAIL;
                        cnt   <= is_wr ? CNT_W'(WR_TAIL - 1) : CNT_W'(RD_TAIL - 1);
                        ce_n  <= 1'b1;
                        oe_n  <= 1'b1;
                        we_n  <= 1'b1;
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                ST_TAIL: begin
                    drive <= drive && (cnt > CNT_W'(WR_TAIL - DH_CYC));
                    if (cnt == '0) state <= ST_IDLE;
                    else           cnt   <= cnt - 1'b1;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Track how long the write strobe has been low, for the pulse-width check.
    always_ff @(posedge clk) begin
        if (!rst_n)    we_low_run <= '0;
        else if (we_n) we_low_run <= '0;
        else           we_low_run <= we_low_run + 1'b1;
    end

    // R3
    we_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !we_n |-> (!ce_n && oe_n));
    // R3
    we_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(we_n) |-> (we_low_run >= 16'(WR_ACT)));
    // R4
    no_contention_chk: assert property (@(posedge clk) disable iff (!rst_n)
        drive |-> oe_n);
    // R6
    busy_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ce_n |-> !req_ready);

endmodule

// File: rtl/sram_ctrl_datapath.sv
// Address/data registers, load capture and response pulses.
// Assumes accept and capture are single-cycle pulses from the sequencer.
module sram_ctrl_datapath #(
    parameter int ADDR_W = 13,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              accept,
    input  logic              capture,
    input  logic              is_wr,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [DATA_W-1:0] dq_i,
    output logic [ADDR_W-1:0] addr_q,
    output logic [DATA_W-1:0] wdata_q,
    output logic [DATA_W-1:0] rdata_q,
    output logic              rsp_valid,
    output logic              wr_done
);

    // Latch the request, capture load data and raise the completion pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q    <= '0;
            wdata_q   <= '0;
            rdata_q   <= '0;
            rsp_valid <= 1'b0;
            wr_done   <= 1'b0;
        end else begin
            rsp_valid <= capture && !is_wr;
            wr_done   <= capture && is_wr;
            if (accept) begin
                addr_q  <= req_addr;
                wdata_q <= req_wdata;
            end
            if (capture && !is_wr) rdata_q <= dq_i;
        end
    end

    // R8
    rsp_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);
    // R9
    resp_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({rsp_valid, wr_done}));

endmodule

// File: rtl/sram_async_ctrl.sv
// Top: turns host load/store requests into timed asynchronous SRAM strobes.
// Assumes the SRAM meets the nanosecond minimums given as parameters.
module sram_async_ctrl
    import sram_ctrl_pkg::*;
#(
    parameter int ADDR_W     = 13,
    parameter int DATA_W     = 8,
    parameter int CLK_NS     = 5,
    parameter int CYC_NS     = 100,
    parameter int ACC_NS     = 100,
    parameter int OE_ACC_NS  = 50,
    parameter int WP_NS      = 80,
    parameter int AW_NS      = 80,
    parameter int DS_NS      = 50,
    parameter int DH_NS      = 5,
    parameter int AH_NS      = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_we,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              req_ready,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              wr_done,
    output logic [ADDR_W-1:0] sram_addr,
    output logic              sram_ce_n,
    output logic              sram_oe_n,
    output logic              sram_we_n,
    output logic [DATA_W-1:0] dq_o,
    output logic              dq_oe,
    input  logic [DATA_W-1:0] dq_i
);

    localparam int CYC_C   = ns_to_cyc(CYC_NS, CLK_NS);
    localparam int AH_C    = ns_to_cyc(AH_NS, CLK_NS);
    localparam int DH_C    = ns_to_cyc(DH_NS, CLK_NS);
    localparam int RD_ACT  = imax2(ns_to_cyc(ACC_NS, CLK_NS), ns_to_cyc(OE_ACC_NS, CLK_NS));
    localparam int WR_ACT  = imax3(ns_to_cyc(WP_NS, CLK_NS), ns_to_cyc(AW_NS, CLK_NS),
                                   ns_to_cyc(DS_NS, CLK_NS));
    localparam int RD_TAIL = imax2(AH_C, CYC_C - RD_ACT);
    localparam int WR_TAIL = imax3(AH_C, DH_C, CYC_C - WR_ACT);
    localparam int CNT_MAX = imax3(imax2(RD_ACT, WR_ACT), RD_TAIL, WR_TAIL);
    localparam int CNT_W   = $clog2(CNT_MAX + 1);

    logic accept, capture, is_wr;

    sram_ctrl_fsm #(
        .RD_ACT (RD_ACT),
        .WR_ACT (WR_ACT),
        .RD_TAIL(RD_TAIL),
        .WR_TAIL(WR_TAIL),
        .DH_CYC (DH_C),
        .CNT_W  (CNT_W)
    ) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .req_valid(req_valid),
        .req_we   (req_we),
        .req_ready(req_ready),
        .accept   (accept),
        .capture  (capture),
        .is_wr    (is_wr),
        .ce_n     (sram_ce_n),
        .oe_n     (sram_oe_n),
        .we_n     (sram_we_n),
        .drive    (dq_oe)
    );

    sram_ctrl_datapath #(
        .ADDR_W(ADDR_W),
        .DATA_W(DATA_W)
    ) u_dp (
        .clk      (clk),
        .rst_n    (rst_n),
        .accept   (accept),
        .capture  (capture),
        .is_wr    (is_wr),
        .req_addr (req_addr),
        .req_wdata(req_wdata),
        .dq_i     (dq_i),
        .addr_q   (sram_addr),
        .wdata_q  (dq_o),
        .rdata_q  (rsp_rdata),
        .rsp_valid(rsp_valid),
        .wr_done  (wr_done)
    );

    // R5
    addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!req_ready && $past(!req_ready)) |-> $stable(sram_addr));

endmodule

// File: tb/sram_async_ctrl_tb.sv
// Cycle-by-cycle reference bench: a timeline model per request plus a pin-level SRAM.
module sram_async_ctrl_tb;

    localparam int AW = 13;
    localparam int DW = 8;
    localparam int CLK_NS = 5;

    function automatic int cyc(input int ns);
        int c;
        c = (ns + CLK_NS - 1) / CLK_NS;
        return (c < 1) ? 1 : c;
    endfunction
    function automatic int mx(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    // R7: counts computed here from the nanosecond minimums.
    localparam int RA = mx(cyc(100), cyc(50));
    localparam int WA = mx(mx(cyc(80), cyc(80)), cyc(50));
    localparam int DH = cyc(5);
    localparam int RT = mx(cyc(10), cyc(100) - RA);
    localparam int WT = mx(mx(cyc(10), DH), cyc(100) - WA);

    logic clk = 0, rst_n = 0;
    logic req_valid = 0, req_we = 0;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_wdata = '0;
    logic req_ready, rsp_valid, wr_done, sram_ce_n, sram_oe_n, sram_we_n, dq_oe;
    logic [DW-1:0] rsp_rdata, dq_o, dq_i;
    logic [AW-1:0] sram_addr;

    always #2.5 clk = ~clk;

    sram_async_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_we(req_we),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_ready(req_ready),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .wr_done(wr_done),
        .sram_addr(sram_addr), .sram_ce_n(sram_ce_n), .sram_oe_n(sram_oe_n),
        .sram_we_n(sram_we_n), .dq_o(dq_o), .dq_oe(dq_oe), .dq_i(dq_i)
    );

    int n_chk = 0, n_fail = 0;
    logic [DW-1:0] pin_mem [int];
    logic [DW-1:0] ref_mem [int];

    function automatic logic [DW-1:0] dflt(input int a);
        return 8'(a) ^ 8'(a >> 8) ^ 8'hA5;
    endfunction

    // Pin-level SRAM read path.
    always @* begin
        if (!sram_ce_n && !sram_oe_n)
            dq_i = pin_mem.exists(int'(sram_addr)) ? pin_mem[int'(sram_addr)] : dflt(int'(sram_addr));
        else
            dq_i = 8'h00;
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h at %0t", req, what, act, exp, $time);
        end
    endtask

    // Operation script.
    localparam int NOPS = 40;
    logic          op_we   [NOPS];
    int            op_addr [NOPS];
    logic [DW-1:0] op_data [NOPS];

    initial begin
        op_we[0] = 0; op_addr[0] = 0;      op_data[0] = 0;
        op_we[1] = 0; op_addr[1] = 8191;   op_data[1] = 0;
        op_we[2] = 1; op_addr[2] = 0;      op_data[2] = 8'h3C;
        op_we[3] = 0; op_addr[3] = 0;      op_data[3] = 0;
        op_we[4] = 1; op_addr[4] = 8191;   op_data[4] = 8'hC3;
        op_we[5] = 0; op_addr[5] = 8191;   op_data[5] = 0;
        op_we[6] = 1; op_addr[6] = 'h1555; op_data[6] = 8'hFF;
        op_we[7] = 1; op_addr[7] = 'h0AAA; op_data[7] = 8'h00;
        op_we[8] = 0; op_addr[8] = 'h1555; op_data[8] = 0;
        op_we[9] = 0; op_addr[9] = 'h0AAA; op_data[9] = 0;
        for (int i = 10; i < NOPS; i++) begin
            op_we[i]   = (i % 2 == 0);
            op_addr[i] = ((i - (i % 2)) * 613) % 8192;
            op_data[i] = 8'(i * 37 + 1);
        end
    end

    bit busy = 0, cur_we = 0, accepted = 0;
    int age = 0, cur_addr = 0, op_idx = 0, gap = 0, cycles = 0;
    logic [DW-1:0] cur_data = '0;
    bit wact = 0;
    int waddr = 0;
    logic [DW-1:0] wbuf = '0;

    initial begin
        int act_n, tail_n, ea, ed;
        bit e_ce, e_oe, e_we, e_drv, e_rsp, e_wd, e_rdy;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(req_ready == 1, "R1", "ready", req_ready, 1);
        chk({sram_ce_n, sram_oe_n, sram_we_n} == 3'b111, "R1", "strobes", {sram_ce_n, sram_oe_n, sram_we_n}, 7);
        chk({dq_oe, rsp_valid, wr_done} == 3'b000, "R1", "drive/resp", {dq_oe, rsp_valid, wr_done}, 0);
        rst_n = 1;
        @(negedge clk);
        chk(req_ready == 1 && sram_ce_n == 1 && dq_oe == 0, "R1", "after release",
            {req_ready, sram_ce_n, dq_oe}, 3'b110);
        forever begin
            @(negedge clk);
            cycles++;
            if (cycles > 20000) begin
                chk(0, "WDOG", "watchdog", cycles, 20000);
                break;
            end
            // Pin-level SRAM write path: commit when a strobe rises.
            if (!sram_ce_n && !sram_we_n && dq_oe) begin
                wact = 1; waddr = int'(sram_addr); wbuf = dq_o;
            end else if (wact && (sram_we_n || sram_ce_n)) begin
                pin_mem[waddr] = wbuf; wact = 0;
            end
            if (accepted) begin req_valid = 0; accepted = 0; end
            if (busy) begin
                age++;
                act_n  = cur_we ? WA : RA;
                tail_n = cur_we ? WT : RT;
                if (age >= act_n + tail_n) busy = 0;
            end
            act_n = cur_we ? WA : RA;
            e_rdy = !busy;
            e_ce  = !(busy && age < act_n);
            e_oe  = !(busy && age < act_n && !cur_we);
            e_we  = !(busy && age < act_n && cur_we);
            e_drv = busy && cur_we && age < act_n + DH;
            e_rsp = busy && !cur_we && age == act_n;
            e_wd  = busy && cur_we && age == act_n;
            // R6 / R10
            chk(req_ready == e_rdy, "R6", "ready", req_ready, e_rdy);
            // R2
            chk(sram_oe_n == e_oe, "R2", "oe_n", sram_oe_n, e_oe);
            chk(sram_ce_n == e_ce, "R2", "ce_n", sram_ce_n, e_ce);
            // R3
            chk(sram_we_n == e_we, "R3", "we_n", sram_we_n, e_we);
            // R4
            chk(dq_oe == e_drv, "R4", "dq_oe", dq_oe, e_drv);
            if (e_drv) chk(dq_o == cur_data, "R4", "dq_o", dq_o, cur_data);
            // R5
            if (busy) chk(int'(sram_addr) == cur_addr, "R5", "addr", sram_addr, cur_addr);
            // R8
            chk(rsp_valid == e_rsp, "R8", "rsp_valid", rsp_valid, e_rsp);
            if (e_rsp) begin
                ed = ref_mem.exists(cur_addr) ? int'(ref_mem[cur_addr]) : int'(dflt(cur_addr));
                chk(int'(rsp_rdata) == ed, "R8", "rsp_rdata", rsp_rdata, ed);
            end
            // R9
            chk(wr_done == e_wd, "R9", "wr_done", wr_done, e_wd);
            // Stimulus: R10 holds valid through busy periods.
            if (!req_valid && op_idx < NOPS) begin
                if (gap > 0) gap--;
                else begin
                    req_valid = 1; req_we = op_we[op_idx];
                    req_addr = AW'(op_addr[op_idx]); req_wdata = op_data[op_idx];
                end
            end
            if (req_valid && !busy) begin
                busy = 1; age = -1; accepted = 1;
                cur_we = req_we; cur_addr = int'(req_addr); cur_data = req_wdata;
                if (cur_we) ref_mem[cur_addr] = cur_data;
                gap = op_idx % 3;
                op_idx++;
            end
            if (op_idx >= NOPS && !busy && !req_valid) begin
                ea = 0;
                repeat (3) @(negedge clk);
                break;
            end
        end
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule